// File: doc/BRIEF.md
# MDIO Management Target with Preamble Resynchronization

This block is the device side of a two-wire serial management link. It watches a management clock and a shared bidirectional data line. It decodes each management frame and serves read and write accesses to a bank of thirty-two 16-bit registers. It does this only when the 5-bit device address in the frame equals the address strapped on its `dev_addr` input.

The block oversamples the management clock with its own system clock. It acts on every rising edge of the management clock to take in a bit. It acts on every falling edge to update the bit it drives. It stays mute after reset until it has counted a preamble of thirty-two consecutive ones on the line. It drops back to that mute, preamble-hunting state whenever a frame carries a malformed start code, opcode or write turnaround.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset `mdio_oe` is 0, and register n (n = 0..31) holds {3'b110, n[4:0], 3'b011, ~n[4:0]} until it is first written.
- R2: After reset the block neither drives the line nor commits writes until it has sampled 32 consecutive ones. A 0 restarts that count.
- R3: A frame is sampled MSB first on MDC rising edges as: start pair 0,1; opcode (1,0 = read, 0,1 = write); 5-bit device address; 5-bit register address; 2 turnaround bits; 16 data bits.
- R4: On a matching read, `mdio_oe` stays 0 for the first turnaround bit. The block then drives 0 for the second turnaround bit, then the 16 register bits MSB first, and it releases the line one bit later. Output changes occur only after MDC falling edges.
- R5: On a matching write, the 16 data bits, MSB first, replace the addressed register once the 16th bit has been sampled.
- R6: A frame whose device address differs from `dev_addr` never raises `mdio_oe` and never changes a register. It is still parsed, so that the next frame is decoded without a preamble.
- R7: Once synchronized, successive frames need no preamble between them.
- R8: A start pair other than 0,1 returns the block to the unsynchronized state, and a fresh 32-ones preamble is needed before it responds.
- R9: An opcode of 0,0 or 1,1 returns the block to the unsynchronized state.
- R10: A write turnaround other than 1,0 returns the block to the unsynchronized state, and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the management link |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 5 | Strapped device address this target answers to |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |

## Verification
The hardest states to reach are the fallbacks from an already synchronized target. Each one needs a correct preamble first, then a frame that breaks at exactly one bit, either the start pair, the opcode or the write turnaround. After that break, a well-formed read must go unanswered. The bench builds each such case from bit-level tasks: a preamble, a truncated bad prefix, then a clean read to the target's own address that must see the line stay released. A fresh preamble and a read of the register the broken write aimed at then prove that the target recovered and that nothing was written.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    // Protocol-fixed field widths
    localparam int DATA_W    = 16;
    localparam int REG_AW    = 5;
    localparam int DEV_AW    = 5;
    localparam int REG_COUNT = 1 << REG_AW;
    localparam int CNT_W     = $clog2(DATA_W);

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_IDLE,
        PS_START,
        PS_OPCODE,
        PS_DEVAD,
        PS_REGAD,
        PS_TURN,
        PS_DATA
    } parse_state_t;

    typedef struct packed {
        logic              valid;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Power-up contents of register idx
    function automatic logic [DATA_W-1:0] reset_word(input logic [REG_AW-1:0] idx);
        return {3'b110, idx, 3'b011, ~idx};
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_raw,
    input  logic mdio_raw,
    output logic mdc_rise,
    output logic mdc_fall,
    output logic mdio_bit
);

    logic [STAGES-1:0] mdc_stage;
    logic [STAGES-1:0] dat_stage;
    logic              mdc_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_stage[g] <= 1'b0;
                    dat_stage[g] <= 1'b1;
                end else begin
                    mdc_stage[g] <= mdc_raw;
                    dat_stage[g] <= mdio_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_stage[g] <= 1'b0;
                    dat_stage[g] <= 1'b1;
                end else begin
                    mdc_stage[g] <= mdc_stage[g-1];
                    dat_stage[g] <= dat_stage[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b0;
        else     mdc_prev <= mdc_stage[STAGES-1];
    end

    assign mdc_rise = mdc_stage[STAGES-1] & ~mdc_prev;
    assign mdc_fall = ~mdc_stage[STAGES-1] & mdc_prev;
    assign mdio_bit = dat_stage[STAGES-1];

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= reset_word(REG_AW'(i));
            else if (wr_req.valid && wr_req.addr == REG_AW'(i))
                mem[i] <= wr_req.data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
    import mdio_slv_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              bit_val,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [REG_AW-1:0] reg_addr,
    output wr_req_t           wr_req,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
    localparam logic [CNT_W-1:0] DEV_LAST  = CNT_W'(DEV_AW - 1);
    localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(REG_AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(PREAMBLE_LEN - 1);

    parse_state_t      state;
    logic [CNT_W-1:0]  cnt;
    logic [PRE_W-1:0]  pre_cnt;
    logic              op_first;
    logic              op_rd;
    logic              ta_first;
    logic              hit;
    logic [DEV_AW-1:0] dev_sh;
    logic [REG_AW-1:0] reg_sh;
    logic [DATA_W-1:0] sh;
    logic              frame_err;
    logic              drive_ta;
    logic              drive_data;

    // Malformed-field detection, evaluated on the bit being sampled
    always_comb begin
        frame_err = 1'b0;
        case (state)
            PS_START:  frame_err = !bit_val;
            PS_OPCODE: frame_err = (cnt == CNT_W'(1)) && (op_first == bit_val);
            PS_TURN:   frame_err = (cnt == CNT_W'(1)) && !op_rd && !(ta_first && !bit_val);
            default:   frame_err = 1'b0;
        endcase
    end

    assign drive_ta   = (state == PS_TURN) && (cnt == CNT_W'(1)) && op_rd && hit;
    assign drive_data = (state == PS_DATA) && op_rd && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_HUNT;
            cnt      <= '0;
            pre_cnt  <= '0;
            op_first <= 1'b0;
            op_rd    <= 1'b0;
            ta_first <= 1'b0;
            hit      <= 1'b0;
            dev_sh   <= '0;
            reg_sh   <= '0;
            sh       <= '0;
            wr_req   <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_req.valid <= 1'b0;
            if (bit_rise) begin
                if (frame_err) begin
                    state   <= PS_HUNT;
                    pre_cnt <= '0;
                    cnt     <= '0;
                end else begin
                    case (state)
                        PS_HUNT: begin
                            if (!bit_val) begin
                                pre_cnt <= '0;
                            end else if (pre_cnt == PRE_LAST) begin
                                pre_cnt <= '0;
                                state   <= PS_IDLE;
                            end else begin
                                pre_cnt <= pre_cnt + PRE_W'(1);
                            end
                        end
                        PS_IDLE: begin
                            if (!bit_val) state <= PS_START;
                        end
                        PS_START: begin
                            state <= PS_OPCODE;
                            cnt   <= '0;
                        end
                        PS_OPCODE: begin
                            if (cnt == '0) begin
                                op_first <= bit_val;
                                cnt      <= CNT_W'(1);
                            end else begin
                                op_rd <= op_first;
                                state <= PS_DEVAD;
                                cnt   <= '0;
                            end
                        end
                        PS_DEVAD: begin
                            dev_sh <= {dev_sh[DEV_AW-2:0], bit_val};
                            if (cnt == DEV_LAST) begin
                                hit   <= ({dev_sh[DEV_AW-2:0], bit_val} == dev_addr);
                                state <= PS_REGAD;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        PS_REGAD: begin
                            reg_sh <= {reg_sh[REG_AW-2:0], bit_val};
                            if (cnt == REG_LAST) begin
                                state <= PS_TURN;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        PS_TURN: begin
                            if (cnt == '0) begin
                                ta_first <= bit_val;
                                cnt      <= CNT_W'(1);
                            end else begin
                                if (op_rd) sh <= rd_word;
                                state <= PS_DATA;
                                cnt   <= '0;
                            end
                        end
                        PS_DATA: begin
                            if (!op_rd) sh <= {sh[DATA_W-2:0], bit_val};
                            if (cnt == DATA_LAST) begin
                                state <= PS_IDLE;
                                cnt   <= '0;
                                if (!op_rd && hit) begin
                                    wr_req.valid <= 1'b1;
                                    wr_req.addr  <= reg_sh;
                                    wr_req.data  <= {sh[DATA_W-2:0], bit_val};
                                end
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        default: state <= PS_HUNT;
                    endcase
                end
            end else if (bit_fall) begin
                if (drive_ta) begin
                    mdio_oe <= 1'b1;
                    mdio_o  <= 1'b0;
                end else if (drive_data) begin
                    mdio_oe <= 1'b1;
                    mdio_o  <= sh[DATA_W-1];
                    sh      <= {sh[DATA_W-2:0], 1'b0};
                end else begin
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b0;
                end
            end
        end
    end

    assign reg_addr = reg_sh;

    AST_NO_DRIVE_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> state != PS_HUNT) else $error("driver enabled while hunting");  // R2

    AST_PREAMBLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pre_cnt < PRE_W'(PREAMBLE_LEN)) else $error("preamble count overran");  // R2

    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o) else $error("first driven bit not zero");  // R4

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> $past(bit_fall)) else $error("enable moved off falling edge");  // R4

    AST_WRITE_ADDR_HIT: assert property (@(posedge clk) disable iff (rst)
        wr_req.valid |-> dev_sh == dev_addr) else $error("write committed for foreign address");  // R6

    AST_ERR_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        (bit_rise && frame_err) |=> state == PS_HUNT) else $error("malformed frame kept sync");  // R8

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_slv_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    logic              mdc_rise;
    logic              mdc_fall;
    logic              mdio_bit;
    logic [REG_AW-1:0] reg_addr;
    logic [DATA_W-1:0] rd_word;
    wr_req_t           wr_req;

    mdio_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .mdc_raw (mdc),
        .mdio_raw(mdio_i),
        .mdc_rise(mdc_rise),
        .mdc_fall(mdc_fall),
        .mdio_bit(mdio_bit)
    );

    mdio_frame_parser #(
        .PREAMBLE_LEN(PREAMBLE_LEN)
    ) i_parser (
        .clk     (clk),
        .rst     (rst),
        .bit_rise(mdc_rise),
        .bit_fall(mdc_fall),
        .bit_val (mdio_bit),
        .dev_addr(dev_addr),
        .rd_word (rd_word),
        .reg_addr(reg_addr),
        .wr_req  (wr_req),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_reg_bank i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .rd_addr(reg_addr),
        .rd_data(rd_word)
    );

endmodule

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module test_mdio_mgmt_slave;

    localparam logic [4:0] OWN   = 5'h0B;
    localparam logic [4:0] OTHER = 5'h14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mdc = 1'b0;
    logic st_en = 1'b0;
    logic st_val = 1'b1;
    logic mdio_o, mdio_oe, line;

    int n_vec = 0;
    int n_bad = 0;
    int clash = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (st_en ? st_val : 1'b1);

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .clk     (clk),
        .rst     (rst),
        .dev_addr(OWN),
        .mdc     (mdc),
        .mdio_i  (line),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    function automatic logic [15:0] pwr_val(input logic [4:0] n);
        return {3'b110, n, 3'b011, ~n};  // R1 encoding
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One MDC period: station drive during low phase, sample just before the rise
    task automatic tick(input logic en, input logic val, output logic ln, output logic oe_s);
        st_en  = en;
        st_val = val;
        repeat (8) @(negedge clk);
        ln   = line;
        oe_s = mdio_oe;
        if (en && mdio_oe) clash++;
        mdc = 1'b1;
        repeat (8) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic drive_bits(input logic [63:0] v, input int n);
        logic l, o;
        for (int i = n - 1; i >= 0; i--) tick(1'b1, v[i], l, o);
    endtask

    task automatic preamble(input int n);
        logic l, o;
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, l, o);
    endtask

    task automatic read_frame(input logic [4:0] dev, input logic [4:0] ra, input bit drv,
                              input logic [15:0] exp, input string req);
        logic l, o;
        logic [15:0] word;
        bit oe_all, oe_any;
        drive_bits({50'd0, 4'b0110, dev, ra}, 14);
        tick(1'b0, 1'b0, l, o);
        chk(o == 1'b0, req, {31'd0, o}, 32'd0);
        tick(1'b0, 1'b0, l, o);
        if (drv) chk(o && !l, req, {30'd0, o, l}, 32'd2);
        else     chk(!o, req, {31'd0, o}, 32'd0);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            tick(1'b0, 1'b0, l, o);
            word[i] = l;
            oe_all &= o;
            oe_any |= o;
        end
        chk(word == (drv ? exp : 16'hFFFF), req, {16'd0, word}, {16'd0, drv ? exp : 16'hFFFF});
        chk(drv ? oe_all : !oe_any, req, {31'd0, oe_any}, {31'd0, drv});
        tick(1'b0, 1'b0, l, o);
        chk(!o, req, {31'd0, o}, 32'd0);
    endtask

    task automatic write_frame(input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] d);
        drive_bits({32'd0, 4'b0101, dev, ra, 2'b10, d}, 32);
        preamble(1);
    endtask

    task automatic t_reset;
        chk(mdio_oe == 1'b0, "R1 reset oe", {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic t_short_preamble;
        preamble(31);
        read_frame(OWN, 5'd3, 1'b0, 16'h0, "R2 31 ones not enough");
    endtask

    task automatic t_sync_and_read;
        preamble(32);
        read_frame(OWN, 5'd3, 1'b1, pwr_val(5'd3), "R1 R4 reset value reg3");
        read_frame(OWN, 5'd31, 1'b1, pwr_val(5'd31), "R7 back-to-back reg31");
    endtask

    task automatic t_writes;
        write_frame(OWN, 5'd7, 16'hA5C3);
        read_frame(OWN, 5'd7, 1'b1, 16'hA5C3, "R5 R3 write reg7");
        write_frame(OWN, 5'd0, 16'h8001);
        read_frame(OWN, 5'd0, 1'b1, 16'h8001, "R5 msb/lsb reg0");
    endtask

    task automatic t_foreign;
        read_frame(OTHER, 5'd7, 1'b0, 16'h0, "R6 foreign read silent");
        write_frame(OTHER, 5'd7, 16'h1234);
        read_frame(OWN, 5'd7, 1'b1, 16'hA5C3, "R6 foreign write ignored");
    endtask

    task automatic t_bad_start;
        drive_bits(64'b00, 2);
        read_frame(OWN, 5'd7, 1'b0, 16'h0, "R8 bad start desync");
        preamble(32);
        read_frame(OWN, 5'd7, 1'b1, 16'hA5C3, "R8 resync");
    endtask

    task automatic t_bad_opcode;
        drive_bits(64'b0111, 4);
        read_frame(OWN, 5'd0, 1'b0, 16'h0, "R9 opcode 11 desync");
        preamble(32);
        drive_bits(64'b0100, 4);
        read_frame(OWN, 5'd0, 1'b0, 16'h0, "R9 opcode 00 desync");
        preamble(32);
        read_frame(OWN, 5'd0, 1'b1, 16'h8001, "R9 resync");
    endtask

    task automatic t_bad_turn;
        drive_bits({32'd0, 4'b0101, OWN, 5'd7, 2'b11, 16'h0BAD}, 32);
        read_frame(OWN, 5'd7, 1'b0, 16'h0, "R10 bad turnaround desync");
        preamble(32);
        read_frame(OWN, 5'd7, 1'b1, 16'hA5C3, "R10 write discarded");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_short_preamble();
        t_sync_and_read();
        t_writes();
        t_foreign();
        t_bad_start();
        t_bad_opcode();
        t_bad_turn();
        chk(clash == 0, "R6 R2 no drive during station bits", clash, 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule